// File: doc/BRIEF.md
# Tagged Serial Receive FIFO

This block buffers characters coming out of an asynchronous serial receiver until software reads them. Each received byte is stored together with its parity and framing error indications, so the error status of a character travels with that character through the queue instead of landing in a shared status word. The FIFO holds 16 entries of 10 bits each: 8 data bits and 2 tag bits.

The receiver presents one character per strobe. Software reads through a strobe that pops the head entry into an 8-bit data register. It can inspect the head entry's tags before popping it. A fill count and a threshold comparison produce a level interrupt. Two sticky flags report characters that arrive ahead of software. The overrun flag records a character arriving while unread data is still queued. The overflow flag records a character dropped because the FIFO was full. A synchronous software reset returns the whole block to its empty state.

Top module: `rx_tag_fifo`

## Requirements
- R1: After `rst_n` is released, `fill_level` is 0, `rd_data` is 0, `ovr_flag`, `ovf_flag`, `head_perr` and `head_ferr` are 0, and `lvl_irq` is 0 for any nonzero threshold.
- R2: A `chr_valid` strobe into a FIFO that is not full stores `chr_data` with `chr_perr` and `chr_ferr` as one entry, and `fill_level` rises by one in the next cycle. The depth is 16 entries.
- R3: A `rd_en` strobe on a non-empty FIFO removes the oldest entry, and its 8 data bits appear on `rd_data` in the next cycle. Bytes come out in arrival order.
- R4: `head_perr` and `head_ferr` show the parity and framing tags that were stored with the entry now at the head. Both are 0 while the FIFO is empty.
- R5: A `chr_valid` strobe that arrives while `fill_level` is nonzero sets `ovr_flag`. Once set, the flag holds. Only `sw_reset` or `rst_n` clears it, and `ovf_clr` has no effect on it.
- R6: A `chr_valid` strobe into a full FIFO drops the character and sets `ovf_flag`. `fill_level` stays at 16 unless a read happens in the same cycle, in which case it becomes 15. The dropped byte is never returned.
- R7: A one on `ovf_clr` clears `ovf_flag`. If an overflow occurs in the same cycle as the clear, the flag ends up set.
- R8: A `rd_en` strobe on an empty FIFO leaves `rd_data` holding its last value and leaves `fill_level` at 0.
- R9: `lvl_irq` is high exactly when `fill_level` is greater than or equal to `lvl_thresh`.
- R10: When `sw_reset` is high at a clock edge, the next cycle shows `fill_level` 0, `rd_data` 0, and every flag and head tag at 0. Any write or read in that same cycle is ignored.
- R11: A read and a write in the same cycle, with the FIFO neither empty nor full, both take effect and leave `fill_level` unchanged. If the FIFO is empty, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sw_reset | input | 1 | Synchronous software reset, one-cycle effect |
| chr_valid | input | 1 | Received character strobe |
| chr_data | input | 8 | Received byte |
| chr_perr | input | 1 | Parity error indication of the received byte |
| chr_ferr | input | 1 | Framing error indication of the received byte |
| rd_en | input | 1 | Pop strobe for the head entry |
| rd_data | output | 8 | Data bits of the most recently popped entry |
| head_perr | output | 1 | Parity tag of the current head entry |
| head_ferr | output | 1 | Framing tag of the current head entry |
| lvl_thresh | input | 5 | Fill threshold for the level interrupt |
| fill_level | output | 5 | Number of queued entries, 0 to 16 |
| lvl_irq | output | 1 | Level interrupt |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovf_flag | output | 1 | Overflow flag, write-one-to-clear |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |

## Verification
The bench fills the queue to its full depth with bytes whose parity and framing tags walk through all four combinations. It then drains the queue, which shows whether the order is kept and whether each tag stays with its own byte rather than its neighbour. Overflow is driven three ways: alone, together with a clear, and together with a read. These three cases separate a dropped character from an accepted one and show which action wins when both happen at once. Further patterns cover a single character into an empty queue against a second one, a read on an empty queue, a read and a write in the same cycle, and a software reset that coincides with a write. Together they tell overrun apart from overflow and show what the reset overrides.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int RXF_DATA_W = 8;

    // one queue word: two tag bits above the data byte (10 bits total)
    typedef struct packed {
        logic                  perr;
        logic                  ferr;
        logic [RXF_DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rxf_ptr_ctrl.sv
`timescale 1ns/1ps
module rxf_ptr_ctrl #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sw_reset,
    input  logic                         wr_req,
    input  logic                         rd_req,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH)-1:0]     wr_ptr,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = wr_req && !full && !sw_reset;
        pop_ok  = rd_req && !empty && !sw_reset;
        st_d    = st_q;
        if (sw_reset) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = step_ptr(st_q.wp);
            if (pop_ok)  st_d.rp = step_ptr(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign count  = st_q.cnt;
endmodule

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  rx_entry_t                wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output rx_entry_t                rdata
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) slot_q[i] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/rxf_flags.sv
`timescale 1ns/1ps
module rxf_flags
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sw_reset,
    input  logic                         chr_valid,
    input  logic                         full,
    input  logic                         empty,
    input  logic                         pop_ok,
    input  logic                         ovf_clr,
    input  rx_entry_t                    head,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    input  logic [$clog2(DEPTH+1)-1:0]   thresh,
    output logic [RXF_DATA_W-1:0]        rd_data,
    output logic                         head_perr,
    output logic                         head_ferr,
    output logic                         ovr,
    output logic                         ovf,
    output logic                         irq
);
    typedef struct packed {
        logic                  ovr;
        logic                  ovf;
        logic [RXF_DATA_W-1:0] rdat;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_reset) begin
            st_d = '0;
        end else begin
            if (ovf_clr)            st_d.ovf  = 1'b0;
            if (chr_valid && full)  st_d.ovf  = 1'b1;
            if (chr_valid && !empty) st_d.ovr = 1'b1;
            if (pop_ok)             st_d.rdat = head.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdat;
    assign ovr       = st_q.ovr;
    assign ovf       = st_q.ovf;
    assign head_perr = !empty && head.perr;
    assign head_ferr = !empty && head.ferr;
    assign irq       = (count >= thresh);
endmodule

// File: rtl/rx_tag_fifo.sv
`timescale 1ns/1ps
module rx_tag_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sw_reset,
    input  logic                           chr_valid,
    input  logic [7:0]                     chr_data,
    input  logic                           chr_perr,
    input  logic                           chr_ferr,
    input  logic                           rd_en,
    output logic [7:0]                     rd_data,
    output logic                           head_perr,
    output logic                           head_ferr,
    input  logic [$clog2(DEPTH+1)-1:0]     lvl_thresh,
    output logic [$clog2(DEPTH+1)-1:0]     fill_level,
    output logic                           lvl_irq,
    output logic                           ovr_flag,
    output logic                           ovf_flag,
    input  logic                           ovf_clr
);
    localparam int AW = $clog2(DEPTH);

    logic          push_ok, pop_ok, full, empty;
    logic [AW-1:0] wr_ptr, rd_ptr;
    rx_entry_t     wr_entry, head_entry;

    assign wr_entry = '{perr: chr_perr, ferr: chr_ferr, data: chr_data};

    rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .wr_req(chr_valid), .rd_req(rd_en),
        .push_ok(push_ok), .pop_ok(pop_ok), .full(full), .empty(empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(fill_level)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_entry),
        .raddr(rd_ptr), .rdata(head_entry)
    );

    rxf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .chr_valid(chr_valid), .full(full), .empty(empty), .pop_ok(pop_ok),
        .ovf_clr(ovf_clr), .head(head_entry), .count(fill_level),
        .thresh(lvl_thresh), .rd_data(rd_data),
        .head_perr(head_perr), .head_ferr(head_ferr),
        .ovr(ovr_flag), .ovf(ovf_flag), .irq(lvl_irq)
    );
endmodule

// File: rtl/rx_tag_fifo_chk.sv
`timescale 1ns/1ps
module rx_tag_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sw_reset,
    input logic                         chr_valid,
    input logic                         rd_en,
    input logic                         ovf_clr,
    input logic [$clog2(DEPTH+1)-1:0]   fill_level,
    input logic [$clog2(DEPTH+1)-1:0]   lvl_thresh,
    input logic                         lvl_irq,
    input logic [7:0]                   rd_data,
    input logic                         ovr_flag,
    input logic                         ovf_flag,
    input logic                         head_perr,
    input logic                         head_ferr
);
    localparam int CW = $clog2(DEPTH + 1);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH)); // R2
    AST_HEAD_TAGS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (!head_perr && !head_ferr)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !sw_reset) |=> ovr_flag); // R5
    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == CW'(DEPTH) && chr_valid && !rd_en && !sw_reset)
        |=> (fill_level == CW'(DEPTH) && ovf_flag)); // R6
    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == CW'(DEPTH) && chr_valid && ovf_clr && !sw_reset) |=> ovf_flag); // R7
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && rd_en && !sw_reset) |=> $stable(rd_data)); // R8
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_irq == (fill_level >= lvl_thresh)); // R9
    AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (fill_level == '0 && !ovr_flag && !ovf_flag && rd_data == '0)); // R10
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .chr_valid(chr_valid),
    .rd_en(rd_en), .ovf_clr(ovf_clr), .fill_level(fill_level),
    .lvl_thresh(lvl_thresh), .lvl_irq(lvl_irq), .rd_data(rd_data),
    .ovr_flag(ovr_flag), .ovf_flag(ovf_flag),
    .head_perr(head_perr), .head_ferr(head_ferr)
);

// File: tb/rx_tag_fifo_bench.sv
`timescale 1ns/1ps
module rx_tag_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0, chr_valid = 1'b0, chr_perr = 1'b0, chr_ferr = 1'b0;
    logic       rd_en = 1'b0, ovf_clr = 1'b0;
    logic [7:0] chr_data = '0;
    logic [7:0] rd_data;
    logic       head_perr, head_ferr, lvl_irq, ovr_flag, ovf_flag;
    logic [4:0] lvl_thresh = 5'd8;
    logic [4:0] fill_level;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rx_tag_fifo u_rx_tag_fifo (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .chr_valid(chr_valid),
        .chr_data(chr_data), .chr_perr(chr_perr), .chr_ferr(chr_ferr),
        .rd_en(rd_en), .rd_data(rd_data), .head_perr(head_perr), .head_ferr(head_ferr),
        .lvl_thresh(lvl_thresh), .fill_level(fill_level), .lvl_irq(lvl_irq),
        .ovr_flag(ovr_flag), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all stimulus tasks start and end at a falling edge
    task automatic push(input logic [7:0] d, input logic p, input logic f);
        chr_valid = 1'b1; chr_data = d; chr_perr = p; chr_ferr = f;
        @(negedge clk);
        chr_valid = 1'b0; chr_perr = 1'b0; chr_ferr = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic soft_reset();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fill", fill_level, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 irq", lvl_irq, 0);
        chk("R1 head tags", {head_perr, head_ferr}, 0);
    endtask

    task automatic t_fill_order();
        soft_reset();
        for (int i = 0; i < 16; i++) begin
            logic [3:0] k;
            k = 4'(i);
            push(8'hA0 + 8'(i), k[0], k[1]);
        end
        chk("R2 fill at depth", fill_level, 16);
        chk("R5 overrun after second char", ovr_flag, 1);
        chk("R6 no overflow at exact depth", ovf_flag, 0);
        for (int i = 0; i < 16; i++) begin
            logic [3:0] k;
            k = 4'(i);
            chk("R4 head perr", head_perr, k[0]);
            chk("R4 head ferr", head_ferr, k[1]);
            pop();
            chk("R3 order", rd_data, 8'hA0 + 8'(i));
        end
        chk("R3 drained", fill_level, 0);
        chk("R4 tags clear when empty", {head_perr, head_ferr}, 0);
    endtask

    task automatic t_irq();
        soft_reset();
        lvl_thresh = 5'd8;
        for (int i = 0; i < 7; i++) push(8'(i), 1'b0, 1'b0);
        chk("R9 below threshold", lvl_irq, 0);
        push(8'h07, 1'b0, 1'b0);
        chk("R9 at threshold", lvl_irq, 1);
        for (int i = 0; i < 5; i++) pop();
        lvl_thresh = 5'd3;
        #1;
        chk("R9 new threshold met", lvl_irq, 1);
        pop();
        chk("R9 under new threshold", lvl_irq, 0);
    endtask

    task automatic t_overflow();
        soft_reset();
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 1'b0, 1'b0);
        push(8'hEE, 1'b1, 1'b1);
        chk("R6 count held", fill_level, 16);
        chk("R6 overflow set", ovf_flag, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk("R7 cleared", ovf_flag, 0);
        chk("R5 ovf_clr leaves overrun", ovr_flag, 1);
        ovf_clr = 1'b1; push(8'hEE, 1'b0, 1'b0); ovf_clr = 1'b0;
        chk("R7 set wins over clear", ovf_flag, 1);
        rd_en = 1'b1; push(8'hEE, 1'b0, 1'b0); rd_en = 1'b0;
        chk("R6 read with drop", fill_level, 15);
        chk("R6 read data", rd_data, 8'h10);
        for (int i = 0; i < 15; i++) pop();
        chk("R6 dropped byte absent", rd_data, 8'h1F);
        chk("R6 empty after drain", fill_level, 0);
    endtask

    task automatic t_empty_read();
        pop();
        chk("R8 data held", rd_data, 8'h1F);
        chk("R8 count held", fill_level, 0);
    endtask

    task automatic t_overrun();
        soft_reset();
        push(8'h31, 1'b0, 1'b0);
        chk("R5 no overrun into empty", ovr_flag, 0);
        pop();
        push(8'h32, 1'b0, 1'b0);
        chk("R5 still clear", ovr_flag, 0);
        push(8'h33, 1'b0, 1'b0);
        chk("R5 set when unread data", ovr_flag, 1);
        pop(); pop();
        chk("R5 sticky after drain", ovr_flag, 1);
    endtask

    task automatic t_simul();
        soft_reset();
        rd_en = 1'b1; push(8'h44, 1'b0, 1'b0); rd_en = 1'b0;
        chk("R11 empty: write only", fill_level, 1);
        chk("R11 empty: data untouched", rd_data, 0);
        push(8'h55, 1'b0, 1'b0);
        rd_en = 1'b1; push(8'h66, 1'b0, 1'b0); rd_en = 1'b0;
        chk("R11 count kept", fill_level, 2);
        chk("R11 read data", rd_data, 8'h44);
        pop();
        chk("R11 next", rd_data, 8'h55);
        pop();
        chk("R11 last", rd_data, 8'h66);
    endtask

    task automatic t_swreset();
        soft_reset();
        lvl_thresh = 5'd4;
        for (int i = 0; i < 17; i++) push(8'h70 + 8'(i), 1'b1, 1'b0);
        pop();
        sw_reset = 1'b1; push(8'h99, 1'b1, 1'b1); sw_reset = 1'b0;
        chk("R10 fill", fill_level, 0);
        chk("R10 ovr", ovr_flag, 0);
        chk("R10 ovf", ovf_flag, 0);
        chk("R10 rd_data", rd_data, 0);
        chk("R10 tags", {head_perr, head_ferr}, 0);
        chk("R10 irq", lvl_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_order();
        t_irq();
        t_overflow();
        t_empty_read();
        t_overrun();
        t_simul();
        t_swreset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule